// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command front end of a single-supply NOR flash device, with a small behavioural word array behind it. A host drives chip enable, write enable and output enable as a simple parallel bus. The block samples that bus on its own clock. A write is recognised on the falling edge of write enable while chip enable is low. A read is active while chip enable and output enable are low and write enable is high. Multi-write unlock sequences are decoded into word program and sector erase operations. The block then runs each operation for a programmed number of cycles instead of real cell timing.

While an operation runs, `ready_o` is low and every read returns a status word instead of array data. An erase can be put on hold. Array reads and programs to other sectors then proceed, and the erase continues after a resume command. An unlock-bypass mode cuts a program down to two writes. A per-sector protect vector and a low-supply input block writes.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset `ready_o` is 1, the decoder is in array-read mode, and every word of the array reads 16'hFFFF.
- R2: With `ce_ni`=0, `oe_ni`=0, `we_ni`=1 and no operation running, `data_o` is the array word at `addr_i[MEM_AW-1:0]`, upper address bits aliasing. With any other combination of these three inputs, `data_o` is 0.
- R3: The writes (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0) and then (target, value) start a program. The address is compared on `addr_i[10:0]` and the command on `data_i[7:0]`. The word becomes old AND value, so bits only move from 1 to 0.
- R4: `ready_o` falls in the cycle after the write that starts an operation. A program holds `ready_o` low for PROG_CYC cycles. An erase holds it low for SECT_WORDS + ERASE_CYC cycles, where SECT_WORDS = 2^(MEM_AW-SECT_AW).
- R5: While an operation runs, a read at any address returns a status word. Bit 7 is the complement of the programmed value's bit 7 for a program, and 0 for an erase. Bit 6 flips after each new read start (falling edge of `oe_ni`) and starts at 0 after reset. All other bits are 0.
- R6: The writes (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55) and then (sector address, 0x30) erase the sector given by `addr_i[MEM_AW-1 -: SECT_AW]`. Each of its words is first cleared to 0, one per cycle, and then all are set to 16'hFFFF. No other sector changes.
- R7: A write that breaks a sequence returns the decoder to array-read mode without side effects. This includes 0xF0 and the wrong address or data at any step.
- R8: The writes (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x20) enter bypass mode. In bypass, (any, 0xA0) then (target, value) programs and stays in bypass. (any, 0xF0) leaves bypass, and other writes are ignored.
- R9: A program or erase aimed at a sector whose `prot_i` bit is 1 is dropped. `ready_o` stays 1 and the array is unchanged.
- R10: A single write of 0xB0 during an erase suspends it, and `ready_o` is 1 on the next cycle. While suspended, reads return array data, and programs to other sectors run. Programs to the erasing sector and new erase commands are dropped. A single write of 0x30 from read mode resumes the erase, and it then completes.
- R11: While `low_vcc_i` is 1, writes are ignored.
- R12: During a running program, every write is ignored. During a running erase, every write except 0xB0 is ignored. The decoder state is not advanced by these writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; write taken on its falling edge |
| oe_ni | input | 1 | Output enable, active low |
| low_vcc_i | input | 1 | Low-supply indicator; blocks writes while high |
| prot_i | input | 2^SECT_AW | Per-sector protect flags |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Array data or status word |
| ready_o | output | 1 | High when no operation is running |

## Verification
A decoder left in the wrong step shows up on the very next write. The program or erase that should start leaves `ready_o` high, or a stray write starts one and pulls `ready_o` low one cycle later. A wrong counter or a lost suspend context moves the rising edge of `ready_o` away from its expected cycle. It can also leave words of the erased sector not at 16'hFFFF, which the next array read exposes. The bench model predicts `data_o` and `ready_o` for every cycle, so a flipped status bit or a wrong array word is caught in the cycle it is read.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] UNL_ADDR0 = 11'h555;
  localparam logic [CMD_AW-1:0] UNL_ADDR1 = 11'h2AA;

  localparam logic [7:0] C_UNL0   = 8'hAA;
  localparam logic [7:0] C_UNL1   = 8'h55;
  localparam logic [7:0] C_PGM    = 8'hA0;
  localparam logic [7:0] C_ESETUP = 8'h80;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_BYP    = 8'h20;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_RESUME = 8'h30;
  localparam logic [7:0] C_RESET  = 8'hF0;

  typedef enum logic [3:0] {
    DEC_READ,
    DEC_UNL1,
    DEC_UNL2,
    DEC_PGM_ARG,
    DEC_ERS_U0,
    DEC_ERS_U1,
    DEC_ERS_SEL,
    DEC_BYP,
    DEC_BYP_ARG
  } dec_state_e;
endpackage

// File: rtl/fcmd_bus_sense.sv
module fcmd_bus_sense (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic oe_ni,
  input  logic low_vcc_i,
  output logic wr_stb_o,
  output logic rd_stb_o,
  output logic rd_act_o
);
  logic we_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_ni;
      oe_q <= oe_ni;
    end
  end

  assign wr_stb_o = ~ce_ni & ~we_ni & we_q & ~low_vcc_i;
  assign rd_stb_o = ~ce_ni & ~oe_ni & oe_q;
  assign rd_act_o = ~ce_ni & ~oe_ni & we_ni;
endmodule

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import flash_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stb_i,
  input  logic [CMD_AW-1:0] addr_i,
  input  logic [7:0]        cmd_i,
  input  logic              busy_i,
  input  logic              erasing_i,
  input  logic              susp_i,
  output logic              prog_req_o,
  output logic              erase_req_o,
  output logic              susp_req_o,
  output logic              resume_req_o
);
  dec_state_e st_q, st_d;
  logic at_a0, at_a1;

  assign at_a0 = (addr_i == UNL_ADDR0);
  assign at_a1 = (addr_i == UNL_ADDR1);

  always_comb begin
    st_d         = st_q;
    prog_req_o   = 1'b0;
    erase_req_o  = 1'b0;
    susp_req_o   = 1'b0;
    resume_req_o = 1'b0;
    if (wr_stb_i) begin
      if (busy_i) begin
        // only suspend is heard while an operation runs
        susp_req_o = erasing_i && (cmd_i == C_SUSP);
      end else begin
        st_d = DEC_READ;
        unique case (st_q)
          DEC_READ: begin
            if (at_a0 && cmd_i == C_UNL0) st_d = DEC_UNL1;
            else resume_req_o = susp_i && (cmd_i == C_RESUME);
          end
          DEC_UNL1: if (at_a1 && cmd_i == C_UNL1) st_d = DEC_UNL2;
          DEC_UNL2: begin
            if (at_a0 && cmd_i == C_PGM)         st_d = DEC_PGM_ARG;
            else if (at_a0 && cmd_i == C_ESETUP) st_d = DEC_ERS_U0;
            else if (at_a0 && cmd_i == C_BYP)    st_d = DEC_BYP;
          end
          DEC_PGM_ARG: prog_req_o = 1'b1;
          DEC_ERS_U0: if (at_a0 && cmd_i == C_UNL0) st_d = DEC_ERS_U1;
          DEC_ERS_U1: if (at_a1 && cmd_i == C_UNL1) st_d = DEC_ERS_SEL;
          DEC_ERS_SEL: erase_req_o = (cmd_i == C_SECT);
          DEC_BYP: begin
            if (cmd_i == C_PGM)        st_d = DEC_BYP_ARG;
            else if (cmd_i != C_RESET) st_d = DEC_BYP;
          end
          DEC_BYP_ARG: begin
            prog_req_o = 1'b1;
            st_d       = DEC_BYP;
          end
          default: st_d = DEC_READ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= DEC_READ;
    else         st_q <= st_d;
  end
endmodule

// File: rtl/fcmd_engine.sv
module fcmd_engine #(
  parameter int DATA_W    = 16,
  parameter int MEM_AW    = 6,
  parameter int SECT_AW   = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8,
  localparam int WORDS    = 1 << MEM_AW,
  localparam int SW_AW    = MEM_AW - SECT_AW,
  localparam int SECT_N   = 1 << SECT_AW,
  localparam int PCW      = $clog2(PROG_CYC + 1),
  localparam int ECW      = $clog2(ERASE_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_req_i,
  input  logic              erase_req_i,
  input  logic              susp_req_i,
  input  logic              resume_req_i,
  input  logic              rd_stb_i,
  input  logic              rd_act_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SECT_N-1:0] prot_i,
  output logic              busy_o,
  output logic              erasing_o,
  output logic              susp_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0]  mem_q [WORDS];
  logic               busy_q, op_prog_q, susp_q, pre_q, tog_q;
  logic [PCW-1:0]     pcnt_q;
  logic [ECW-1:0]     ecnt_q;
  logic [SW_AW-1:0]   idx_q;
  logic [SECT_AW-1:0] esect_q;
  logic [MEM_AW-1:0]  pa_q;
  logic [DATA_W-1:0]  pd_q;
  logic [SECT_AW-1:0] req_sect;
  logic               prog_ok, erase_ok;

  function automatic logic [SECT_AW-1:0] sect_of(input int w);
    return SECT_AW'(w >> SW_AW);
  endfunction

  assign req_sect = addr_i[MEM_AW-1 -: SECT_AW];
  assign prog_ok  = prog_req_i & ~prot_i[req_sect] & ~(susp_q & (req_sect == esect_q));
  assign erase_ok = erase_req_i & ~susp_q & ~prot_i[req_sect];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
      busy_q    <= 1'b0;
      op_prog_q <= 1'b0;
      susp_q    <= 1'b0;
      pre_q     <= 1'b0;
      tog_q     <= 1'b0;
      pcnt_q    <= '0;
      ecnt_q    <= '0;
      idx_q     <= '0;
      esect_q   <= '0;
      pa_q      <= '0;
      pd_q      <= '0;
    end else begin
      if (busy_q && rd_stb_i) tog_q <= ~tog_q;
      if (busy_q) begin
        if (op_prog_q) begin
          if (pcnt_q == PCW'(1)) begin
            mem_q[pa_q] <= mem_q[pa_q] & pd_q;
            busy_q      <= 1'b0;
          end else begin
            pcnt_q <= pcnt_q - 1'b1;
          end
        end else if (susp_req_i) begin
          susp_q <= 1'b1;
          busy_q <= 1'b0;
        end else if (pre_q) begin
          // pre-program: one word of the sector cleared per cycle
          mem_q[{esect_q, idx_q}] <= '0;
          if (idx_q == '1) begin
            pre_q  <= 1'b0;
            ecnt_q <= ECW'(ERASE_CYC);
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end else if (ecnt_q == ECW'(1)) begin
          for (int i = 0; i < WORDS; i++)
            if (sect_of(i) == esect_q) mem_q[i] <= '1;
          busy_q <= 1'b0;
        end else begin
          ecnt_q <= ecnt_q - 1'b1;
        end
      end else if (prog_ok) begin
        busy_q    <= 1'b1;
        op_prog_q <= 1'b1;
        pcnt_q    <= PCW'(PROG_CYC);
        pa_q      <= addr_i;
        pd_q      <= data_i;
      end else if (erase_ok) begin
        busy_q    <= 1'b1;
        op_prog_q <= 1'b0;
        pre_q     <= 1'b1;
        idx_q     <= '0;
        esect_q   <= req_sect;
      end else if (resume_req_i && susp_q) begin
        busy_q    <= 1'b1;
        op_prog_q <= 1'b0;
        susp_q    <= 1'b0;
      end
    end
  end

  always_comb begin
    data_o = '0;
    if (rd_act_i) begin
      if (busy_q) begin
        data_o[7] = op_prog_q ? ~pd_q[7] : 1'b0;
        data_o[6] = tog_q;
      end else begin
        data_o = mem_q[addr_i];
      end
    end
  end

  assign busy_o    = busy_q;
  assign erasing_o = busy_q & ~op_prog_q;
  assign susp_o    = susp_q;
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int MEM_AW    = 6,
  parameter int SECT_AW   = 2,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8,
  localparam int SECT_N   = 1 << SECT_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              low_vcc_i,
  input  logic [SECT_N-1:0] prot_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ready_o
);
  logic wr_stb, rd_stb, rd_act;
  logic busy, erasing, susp;
  logic prog_req, erase_req, susp_req, resume_req;

  fcmd_bus_sense u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .oe_ni     (oe_ni),
    .low_vcc_i (low_vcc_i),
    .wr_stb_o  (wr_stb),
    .rd_stb_o  (rd_stb),
    .rd_act_o  (rd_act)
  );

  fcmd_decode u_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_stb_i     (wr_stb),
    .addr_i       (addr_i[CMD_AW-1:0]),
    .cmd_i        (data_i[7:0]),
    .busy_i       (busy),
    .erasing_i    (erasing),
    .susp_i       (susp),
    .prog_req_o   (prog_req),
    .erase_req_o  (erase_req),
    .susp_req_o   (susp_req),
    .resume_req_o (resume_req)
  );

  fcmd_engine #(
    .DATA_W    (DATA_W),
    .MEM_AW    (MEM_AW),
    .SECT_AW   (SECT_AW),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) u_eng (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_req_i   (prog_req),
    .erase_req_i  (erase_req),
    .susp_req_i   (susp_req),
    .resume_req_i (resume_req),
    .rd_stb_i     (rd_stb),
    .rd_act_i     (rd_act),
    .addr_i       (addr_i[MEM_AW-1:0]),
    .data_i       (data_i),
    .prot_i       (prot_i),
    .busy_o       (busy),
    .erasing_o    (erasing),
    .susp_o       (susp),
    .data_o       (data_o)
  );

  assign ready_o = ~busy;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              low_vcc_i,
  input logic              busy,
  input logic              erasing,
  input logic              susp,
  input logic              rd_act,
  input logic [DATA_W-1:0] data_o
);
  // R11
  low_vcc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && low_vcc_i |=> ready_o);

  // R5
  status_zero_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && rd_act |-> (data_o[DATA_W-1:8] == '0) && (data_o[5:0] == '0));

  // R5
  erase_poll_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erasing && rd_act |-> !data_o[7]);

  // R10
  susp_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp) |-> ready_o);

  // R10
  susp_from_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(susp) |-> $past(erasing));

  // R10
  susp_no_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp |-> !erasing);
endmodule

bind flash_cmd_fsm flash_cmd_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .low_vcc_i (low_vcc_i),
  .busy      (busy),
  .erasing   (erasing),
  .susp      (susp),
  .rd_act    (rd_act),
  .data_o    (data_o)
);

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;
  localparam int WORDS = 64;
  localparam int SW    = 16;
  localparam int PC    = 4;
  localparam int EC    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lv = 1'b0;
  logic [3:0]  prot = 4'b0;
  logic [10:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic        ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_fsm dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ce_ni     (ce_n),
    .we_ni     (we_n),
    .oe_ni     (oe_n),
    .low_vcc_i (lv),
    .prot_i    (prot),
    .addr_i    (addr),
    .data_i    (din),
    .data_o    (dout),
    .ready_o   (ready)
  );

  // behavioural reference model
  logic [15:0] m_mem [WORDS];
  int          m_st, m_pcnt, m_ecnt, m_idx, m_esec, m_pa;
  bit          m_busy, m_isprog, m_susp, m_pre, m_tog, m_weq, m_oeq;
  logic [15:0] m_pd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) m_mem[i] = 16'hFFFF;
      m_st = 0; m_pcnt = 0; m_ecnt = 0; m_idx = 0; m_esec = 0; m_pa = 0;
      m_busy = 0; m_isprog = 0; m_susp = 0; m_pre = 0; m_tog = 0;
      m_weq = 1; m_oeq = 1; m_pd = '0;
    end else begin
      bit wr, rd, sp, se, sus, res, was_busy;
      int a, d, s, ns;
      wr = !ce_n && !we_n && m_weq && !lv;
      rd = !ce_n && !oe_n && m_oeq;
      a = int'(addr); d = int'(din[7:0]); s = (a % WORDS) / SW;
      sp = 0; se = 0; sus = 0; res = 0; was_busy = m_busy;
      if (wr) begin
        if (m_busy) sus = !m_isprog && d == 'hB0;
        else begin
          ns = 0;
          case (m_st)
            0: if (a == 'h555 && d == 'hAA) ns = 1; else res = m_susp && d == 'h30;
            1: if (a == 'h2AA && d == 'h55) ns = 2;
            2: if (a == 'h555) begin
                 if (d == 'hA0) ns = 3; else if (d == 'h80) ns = 4; else if (d == 'h20) ns = 7;
               end
            3: sp = 1;
            4: if (a == 'h555 && d == 'hAA) ns = 5;
            5: if (a == 'h2AA && d == 'h55) ns = 6;
            6: se = (d == 'h30);
            7: if (d == 'hA0) ns = 8; else if (d != 'hF0) ns = 7;
            8: begin sp = 1; ns = 7; end
            default: ns = 0;
          endcase
          m_st = ns;
        end
      end
      if (m_busy) begin
        if (m_isprog) begin
          if (m_pcnt == 1) begin m_mem[m_pa] = m_mem[m_pa] & m_pd; m_busy = 0; end
          else m_pcnt--;
        end else if (sus) begin
          m_susp = 1; m_busy = 0;
        end else if (m_pre) begin
          m_mem[m_esec * SW + m_idx] = 16'h0000;
          if (m_idx == SW - 1) begin m_pre = 0; m_ecnt = EC; end else m_idx++;
        end else if (m_ecnt == 1) begin
          for (int i = 0; i < SW; i++) m_mem[m_esec * SW + i] = 16'hFFFF;
          m_busy = 0;
        end else m_ecnt--;
      end else if (sp && !prot[s] && !(m_susp && s == m_esec)) begin
        m_busy = 1; m_isprog = 1; m_pcnt = PC; m_pa = a % WORDS; m_pd = din;
      end else if (se && !m_susp && !prot[s]) begin
        m_busy = 1; m_isprog = 0; m_pre = 1; m_idx = 0; m_esec = s;
      end else if (res && m_susp) begin
        m_busy = 1; m_isprog = 0; m_susp = 0;
      end
      if (was_busy && rd) m_tog = !m_tog;
      m_weq = we_n; m_oeq = oe_n;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [15:0] e;
      e = '0;
      if (!ce_n && !oe_n && we_n) begin
        if (m_busy) begin e[7] = m_isprog ? ~m_pd[7] : 1'b0; e[6] = m_tog; end
        else e = m_mem[addr[5:0]];
      end
      n_tests++;
      if (dout !== e || ready !== !m_busy) begin
        n_fail++;
        $display("FAIL R4 model cycle: data=%h ready=%b exp data=%h ready=%b", dout, ready, e, !m_busy);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    ce_n = 0; we_n = 0; addr = a; din = d;
    @(posedge clk); #1;
    we_n = 1; ce_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk); d = dout;
    @(posedge clk); #1;
    oe_n = 1; ce_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic pgm(input logic [10:0] a, input logic [15:0] d);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'hA0); wr(a, d);
  endtask

  task automatic ers(input logic [10:0] a);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'h80);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(a, 16'h30);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (ready) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic ready_is(input string req, input logic exp);
    @(negedge clk);
    chk(req, {15'b0, ready}, {15'b0, exp});
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: act=hung exp=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    #9 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    ready_is("R1 ready after reset", 1'b1);
    rd(11'h000, v); chk("R1 erased word", v, 16'hFFFF);
    rd(11'h03F, v); chk("R1 erased last word", v, 16'hFFFF);
    // R2 no output without read enables
    @(negedge clk); chk("R2 idle output", dout, 16'h0000);
    @(posedge clk); #1;

    // R3 program, R5 status
    pgm(11'h005, 16'h1234);
    rd(11'h007, v); rd(11'h007, v2);
    chk("R5 status first read", v, 16'h0080);
    chk("R5 status toggled", v2, 16'h00C0);
    wait_ready();
    rd(11'h005, v); chk("R3 programmed", v, 16'h1234);
    rd(11'h045, v); chk("R2 alias read", v, 16'h1234);
    pgm(11'h005, 16'hFF0F); wait_ready();
    rd(11'h005, v); chk("R3 and with old", v, 16'h1204);

    // R7 broken sequences
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h123, 16'hA0); wr(11'h006, 16'h0000);
    ready_is("R7 no start", 1'b1);
    rd(11'h006, v); chk("R7 word kept", v, 16'hFFFF);
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'hF0);
    pgm(11'h006, 16'h00F0); wait_ready();
    rd(11'h006, v); chk("R7 decoder recovered", v, 16'h00F0);

    // R8 bypass
    wr(11'h555, 16'hAA); wr(11'h2AA, 16'h55); wr(11'h555, 16'h20);
    wr(11'h000, 16'hA0); wr(11'h00A, 16'h00FF); wait_ready();
    rd(11'h00A, v); chk("R8 bypass program", v, 16'h00FF);
    wr(11'h000, 16'h77);
    wr(11'h000, 16'hA0); wr(11'h00B, 16'hAAAA); wait_ready();
    rd(11'h00B, v); chk("R8 bypass stays", v, 16'hAAAA);
    wr(11'h000, 16'hF0);
    wr(11'h000, 16'hA0); wr(11'h00C, 16'h0000);
    ready_is("R8 bypass left", 1'b1);
    rd(11'h00C, v); chk("R8 no program after exit", v, 16'hFFFF);

    pgm(11'h014, 16'h4321); wait_ready();

    // R9 protection
    prot = 4'b0100;
    pgm(11'h021, 16'h0000);
    ready_is("R9 protected program", 1'b1);
    ers(11'h020);
    ready_is("R9 protected erase", 1'b1);
    rd(11'h021, v); chk("R9 protected word", v, 16'hFFFF);
    prot = 4'b0000;

    // R6 sector erase
    ers(11'h000);
    rd(11'h030, v); chk("R5 erase status", v & 16'hFFBF, 16'h0000);
    wait_ready();
    rd(11'h005, v); chk("R6 sector word 5", v, 16'hFFFF);
    rd(11'h00A, v); chk("R6 sector word 10", v, 16'hFFFF);
    rd(11'h014, v); chk("R6 other sector kept", v, 16'h4321);

    // R10 suspend and resume
    pgm(11'h003, 16'h5555); wait_ready();
    ers(11'h000);
    wr(11'h000, 16'hB0);
    ready_is("R10 suspended ready", 1'b1);
    rd(11'h014, v); chk("R10 read in suspend", v, 16'h4321);
    pgm(11'h015, 16'h0F0F); wait_ready();
    rd(11'h015, v); chk("R10 program in suspend", v, 16'h0F0F);
    pgm(11'h004, 16'h0000);
    ready_is("R10 erasing sector locked", 1'b1);
    wr(11'h000, 16'h30);
    ready_is("R10 resumed busy", 1'b0);
    wait_ready();
    rd(11'h003, v); chk("R10 erase completed", v, 16'hFFFF);
    rd(11'h015, v); chk("R10 other sector kept", v, 16'h0F0F);

    // R11 low supply
    lv = 1;
    pgm(11'h019, 16'h0000);
    ready_is("R11 write blocked", 1'b1);
    lv = 0;
    rd(11'h019, v); chk("R11 word kept", v, 16'hFFFF);

    // R12 writes while programming
    pgm(11'h01A, 16'h00FF);
    wr(11'h555, 16'hAA);
    wr(11'h000, 16'hB0);
    wait_ready();
    rd(11'h01A, v); chk("R12 program result", v, 16'h00FF);
    pgm(11'h01B, 16'h1111); wait_ready();
    rd(11'h01B, v); chk("R12 decoder untouched", v, 16'h1111);

    finish_run();
  end
endmodule